// File: doc/BRIEF.md
# Parallel Port Enhanced Transfer Bridge

This block sits between a host register interface and a byte-wide peripheral transaction port. It models the host view of an enhanced parallel port. Host accesses to the address port (offset 3) and the data port (offset 4) become peripheral address or data cycles. Each cycle is allowed only when the stored control byte holds one exact pattern. Accesses to the data, status and control offsets are forwarded as single peripheral commands. A data or control write that would not change the stored value is dropped.

Every peripheral byte transaction is a request held until an acknowledge arrives. The acknowledge can carry an error flag. A programmable cycle timer declares a failure if no acknowledge arrives in time. Any failure sets a sticky timeout flag, which appears in bit 0 of every status read. A 16-bit or 32-bit access at the data port is split into 2 or 4 byte transactions, sent least significant byte first. The host access stalls until the whole sequence has completed or failed.

A host access is a one-cycle `hostReq` pulse that is accepted while the block is idle. `hostWait` is high while peripheral work is in flight. `hostDone` marks the single cycle in which `hostRdata` is valid.

Top module: `epp_bridge`

## Requirements
- R1: After reset the control byte is 0xCC, the last written data byte is 0xFF, the timeout flag is 0, and `hostWait`, `hostDone` and `perReq` are low.
- R2: A write to offset 3 (op code 3) or offset 4 (op code 4) reaches the peripheral only when control AND 0x2F equals 0x04. Otherwise it is dropped with no request.
- R3: A read of offset 3 (op code 5) or offset 4 (op code 6) reaches the peripheral only when control AND 0x2F equals 0x24. Otherwise it returns 0xFFFFFFFF with no request.
- R4: At offset 4, `hostSize` 1 gives 2 byte transactions and `hostSize` 2 or 3 gives 4, sent least significant byte first. Read bytes are assembled with the first byte in bits 7:0, and byte lanes that are not read return 0xFF.
- R5: A byte transaction fails if it is acknowledged with `perErr` high or if the timer expires. A failure sets the sticky timeout flag, skips the remaining bytes of the access, and leaves those lanes at 0xFF.
- R6: With `toLimit` = L, an acknowledge seen in clock cycles 0..L of a request counts, including cycle L itself. With no acknowledge by cycle L, the byte fails.
- R7: A read of offset 1 issues op code 7 and returns the peripheral byte with bit 0 replaced by the timeout flag. A write of offset 1 with bit 0 set clears the flag; with bit 0 clear it leaves the flag unchanged.
- R8: A write of offset 0 issues op code 0 carrying the byte, unless the byte equals the last written data byte, in which case there is no request.
- R9: A write of offset 2 has bits 7:6 forced to 1. If the result equals the stored control byte, there is no request. A read of offset 2 returns the stored control byte with no request.
- R10: A control write that flips bit 5 (direction) first issues op code 2 carrying 0x01 or 0x00 for the new direction, then op code 1 carrying the new control byte with bit 5 cleared. Any other changing control write issues only op code 1 with the full byte.
- R11: An access that needs no peripheral work raises `hostDone` one cycle after the request. An access that needs peripheral work holds `hostWait` high until it ends. `hostDone` lasts exactly one cycle.
- R12: `perReq` stays high with `perOp` and `perWdata` stable until acknowledge or expiry. It drops for at least one cycle between the bytes of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle access request, taken while idle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes (offset 4 only) |
| hostWdata | input | 32 | Write data, low byte first |
| hostRdata | output | 32 | Read data, valid with hostDone |
| hostWait | output | 1 | Peripheral work in flight |
| hostDone | output | 1 | Access finished this cycle |
| toLimit | input | 16 | Last cycle in which an acknowledge is accepted |
| perReq | output | 1 | Peripheral byte request |
| perOp | output | 4 | Transaction op code |
| perWdata | output | 8 | Byte to the peripheral |
| perRdata | input | 8 | Byte from the peripheral, taken with perAck |
| perAck | input | 1 | Transaction response |
| perErr | input | 1 | Response reports failure |

## Verification
The timer expiry and a late acknowledge can fall on the same clock edge. The bench delays the acknowledge to exactly cycle `toLimit` and expects success. It then delays it one cycle more and expects a failure, a set flag and an all-ones read. A failure can also occur in the middle of a burst, in the same access as bytes that were already captured. This is provoked by returning an error on the second byte of a four-byte read, and judged by the request count and the lane contents.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int HOST_W = BYTE_W * LANES;
  localparam int IDX_W  = $clog2(LANES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int TMR_W  = 16;
  localparam int DIR_BIT = 5;

  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RESET = 8'hFF;
  localparam logic [BYTE_W-1:0] GATE_MASK  = 8'h2F;
  localparam logic [BYTE_W-1:0] GATE_WR    = 8'h04;
  localparam logic [BYTE_W-1:0] GATE_RD    = 8'h24;
  localparam logic [BYTE_W-1:0] DIR_MASK   = 8'h20;

  typedef enum logic [3:0] {
    OP_WR_DATA = 4'd0,
    OP_WR_CTRL = 4'd1,
    OP_DIR_CHG = 4'd2,
    OP_ADDR_WR = 4'd3,
    OP_DATA_WR = 4'd4,
    OP_ADDR_RD = 4'd5,
    OP_DATA_RD = 4'd6,
    OP_RD_STAT = 4'd7,
    OP_RD_DATA = 4'd8
  } perOp_e;

  typedef struct packed {
    logic             accept;
    logic             wrData;
    logic             wrCtrl;
    logic             clrFlag;
    logic             setFlag;
    logic             capture;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;
endpackage

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic [BYTE_W-1:0] ctrlReg,
  input  logic [BYTE_W-1:0] datawReg,
  input  logic [TMR_W-1:0]  toLimit,
  input  logic              perAck,
  input  logic              perErr,
  output logic              perReq,
  output perOp_e            perOp,
  output logic              hostWait,
  output logic              hostDone,
  output dpStrobe_t         stb
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP, S_DONE} state_e;

  state_e            state;
  logic [IDX_W-1:0]  idx, lastIdx;
  perOp_e            opA, opB;
  logic [TMR_W-1:0]  tmr;

  logic [CNT_W-1:0]  planN, burstN;
  perOp_e            planA, planB;
  logic              planData, planCtrl, planClr;
  logic [BYTE_W-1:0] ctrlNew;
  logic              wrOk, rdOk;
  logic              accept, expire, byteEnd, byteFail;

  // Decide the transaction plan for an incoming access
  always_comb begin
    ctrlNew  = hostByte | CTRL_FORCE;
    wrOk     = (ctrlReg & GATE_MASK) == GATE_WR;
    rdOk     = (ctrlReg & GATE_MASK) == GATE_RD;
    case (hostSize)
      2'd0:    burstN = CNT_W'(1);
      2'd1:    burstN = CNT_W'(2);
      default: burstN = CNT_W'(LANES);
    endcase
    planN    = '0;
    planA    = OP_WR_DATA;
    planB    = OP_WR_CTRL;
    planData = 1'b0;
    planCtrl = 1'b0;
    planClr  = 1'b0;
    if (hostWe) begin
      case (hostAddr)
        3'd0: if (hostByte != datawReg) begin
          planN = CNT_W'(1); planA = OP_WR_DATA; planData = 1'b1;
        end
        3'd1: planClr = hostByte[0];
        3'd2: if (ctrlNew != ctrlReg) begin
          planCtrl = 1'b1;
          if (ctrlNew[DIR_BIT] != ctrlReg[DIR_BIT]) begin
            planN = CNT_W'(2); planA = OP_DIR_CHG; planB = OP_WR_CTRL;
          end else begin
            planN = CNT_W'(1); planA = OP_WR_CTRL;
          end
        end
        3'd3: if (wrOk) begin planN = CNT_W'(1); planA = OP_ADDR_WR; end
        3'd4: if (wrOk) begin planN = burstN; planA = OP_DATA_WR; planB = OP_DATA_WR; end
        default: ;
      endcase
    end else begin
      case (hostAddr)
        3'd0: begin planN = CNT_W'(1); planA = OP_RD_DATA; end
        3'd1: begin planN = CNT_W'(1); planA = OP_RD_STAT; end
        3'd3: if (rdOk) begin planN = CNT_W'(1); planA = OP_ADDR_RD; end
        3'd4: if (rdOk) begin planN = burstN; planA = OP_DATA_RD; planB = OP_DATA_RD; end
        default: ;
      endcase
    end
  end

  assign accept   = (state == S_IDLE) && hostReq;
  assign expire   = !perAck && (tmr == toLimit);
  assign byteEnd  = (state == S_RUN) && (perAck || expire);
  assign byteFail = byteEnd && !(perAck && !perErr);

  assign perReq   = (state == S_RUN);
  assign perOp    = (idx == '0) ? opA : opB;
  assign hostWait = (state == S_RUN) || (state == S_GAP);
  assign hostDone = (state == S_DONE);

  always_comb begin
    stb.accept  = accept;
    stb.wrData  = accept && planData;
    stb.wrCtrl  = accept && planCtrl;
    stb.clrFlag = accept && planClr;
    stb.setFlag = byteFail;
    stb.capture = byteEnd && !byteFail;
    stb.idx     = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      opA     <= OP_WR_DATA;
      opB     <= OP_WR_DATA;
      tmr     <= '0;
    end else begin
      case (state)
        S_IDLE: if (hostReq) begin
          idx     <= '0;
          tmr     <= '0;
          opA     <= planA;
          opB     <= planB;
          lastIdx <= IDX_W'(planN - CNT_W'(1));
          state   <= (planN == '0) ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (byteEnd) state <= (byteFail || idx == lastIdx) ? S_DONE : S_GAP;
          else         tmr   <= tmr + TMR_W'(1);
        end
        S_GAP: begin
          idx   <= idx + IDX_W'(1);
          tmr   <= '0;
          state <= S_RUN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && !perAck && tmr != toLimit) |=> (perReq && $stable(perOp)));
  // R12
  req_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && perAck) |=> !perReq);
  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && (perOp == OP_ADDR_WR || perOp == OP_DATA_WR)) |-> ((ctrlReg & GATE_MASK) == GATE_WR));
  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && (perOp == OP_ADDR_RD || perOp == OP_DATA_RD)) |-> ((ctrlReg & GATE_MASK) == GATE_RD));
endmodule

// File: rtl/epp_dpath.sv
module epp_dpath
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              hostWe,
  input  logic [2:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  input  perOp_e            perOp,
  input  logic [BYTE_W-1:0] perRdata,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] datawReg,
  output logic [BYTE_W-1:0] perWdata,
  output logic [HOST_W-1:0] hostRdata
);
  logic                          toFlag, dirChg, cmdWe;
  logic [2:0]                    cmdAddr;
  logic [LANES-1:0][BYTE_W-1:0]  cmdData, rdBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      datawReg <= DATA_RESET;
      toFlag   <= 1'b0;
      dirChg   <= 1'b0;
      cmdWe    <= 1'b0;
      cmdAddr  <= '0;
      cmdData  <= '0;
      rdBuf    <= '1;
    end else begin
      if (stb.accept) begin
        cmdWe   <= hostWe;
        cmdAddr <= hostAddr;
        cmdData <= hostWdata;
        rdBuf   <= '1;
        dirChg  <= 1'b0;
      end
      if (stb.wrData) datawReg <= hostWdata[BYTE_W-1:0];
      if (stb.wrCtrl) begin
        ctrlReg <= hostWdata[BYTE_W-1:0] | CTRL_FORCE;
        dirChg  <= hostWdata[DIR_BIT] != ctrlReg[DIR_BIT];
      end
      if (stb.capture) rdBuf[stb.idx] <= perRdata;
      if (stb.setFlag)      toFlag <= 1'b1;
      else if (stb.clrFlag) toFlag <= 1'b0;
    end
  end

  always_comb begin
    case (perOp)
      OP_DIR_CHG: perWdata = BYTE_W'(ctrlReg[DIR_BIT]);
      OP_WR_CTRL: perWdata = dirChg ? (ctrlReg & ~DIR_MASK) : ctrlReg;
      OP_WR_DATA: perWdata = datawReg;
      default:    perWdata = cmdData[stb.idx];
    endcase
  end

  always_comb begin
    hostRdata = rdBuf;
    if (!cmdWe && cmdAddr == 3'd2) hostRdata[BYTE_W-1:0] = ctrlReg;
    if (!cmdWe && cmdAddr == 3'd1) hostRdata[0] = toFlag;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(stb.setFlag));
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toFlag) |-> $past(stb.clrFlag));
endmodule

// File: rtl/epp_bridge.sv
module epp_bridge
  import epp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostWait,
  output logic              hostDone,
  input  logic [TMR_W-1:0]  toLimit,
  output logic              perReq,
  output logic [3:0]        perOp,
  output logic [BYTE_W-1:0] perWdata,
  input  logic [BYTE_W-1:0] perRdata,
  input  logic              perAck,
  input  logic              perErr
);
  dpStrobe_t         stb;
  perOp_e            opCode;
  logic [BYTE_W-1:0] ctrlReg, datawReg;

  assign perOp = opCode;

  epp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostSize (hostSize),
    .hostByte (hostWdata[BYTE_W-1:0]),
    .ctrlReg  (ctrlReg),
    .datawReg (datawReg),
    .toLimit  (toLimit),
    .perAck   (perAck),
    .perErr   (perErr),
    .perReq   (perReq),
    .perOp    (opCode),
    .hostWait (hostWait),
    .hostDone (hostDone),
    .stb      (stb)
  );

  epp_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .perOp     (opCode),
    .perRdata  (perRdata),
    .ctrlReg   (ctrlReg),
    .datawReg  (datawReg),
    .perWdata  (perWdata),
    .hostRdata (hostRdata)
  );
endmodule

// File: tb/tb_epp_bridge.sv
`timescale 1ns/1ps
module tb_epp_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostWait, hostDone, perReq;
  logic [15:0] toLimit = 16'd8;
  logic [3:0]  perOp;
  logic [7:0]  perWdata;
  logic [7:0]  perRdata = '0;
  logic        perAck = 1'b0, perErr = 1'b0;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  // peripheral model state
  int ackDelay = 0, errAt = 99, cyc = 0, nAck = 0, nLog = 0, reqStarts = 0;
  logic [7:0] rdVals [4];
  logic [3:0] logOp  [16];
  logic [7:0] logDat [16];

  epp_bridge dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostWait(hostWait), .hostDone(hostDone),
    .toLimit(toLimit), .perReq(perReq), .perOp(perOp), .perWdata(perWdata),
    .perRdata(perRdata), .perAck(perAck), .perErr(perErr)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && perReq) begin
      if (cyc == 0) reqStarts++;
      if (cyc == ackDelay) begin
        perAck   = 1'b1;
        perErr   = (nAck == errAt);
        perRdata = (nAck < 4) ? rdVals[nAck] : 8'h00;
        if (nLog < 16) begin logOp[nLog] = perOp; logDat[nLog] = perWdata; end
        nLog++;
        nAck++;
      end else begin
        perAck = 1'b0;
        perErr = 1'b0;
      end
      cyc++;
    end else begin
      cyc = 0; perAck = 1'b0; perErr = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clearLog();
    nLog = 0; nAck = 0; reqStarts = 0; errAt = 99; ackDelay = 0;
  endtask

  task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int cycles, output bit sawWait);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostSize = sz; hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    cycles = 1; sawWait = 1'b0;
    while (!hostDone && cycles < 1000) begin
      sawWait |= hostWait;
      @(negedge clk);
      cycles++;
    end
    rd = hostRdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] rd; int c; bit w;
    access(1'b1, a, sz, wd, rd, c, w);
  endtask

  task automatic rdReg(input logic [2:0] a, input logic [1:0] sz, output logic [31:0] rd);
    int c; bit w;
    access(1'b0, a, sz, 32'h0, rd, c, w);
  endtask

  task automatic expLog(input string r, input int i, input int op, input logic [7:0] dat);
    chk(r, {28'h0, logOp[i]}, op);
    chk(r, {24'h0, logDat[i]}, {24'h0, dat});
  endtask

  task automatic testReset();
    logic [31:0] rd;
    chk("R1 wait", {31'h0, hostWait}, 0);
    chk("R1 done", {31'h0, hostDone}, 0);
    chk("R1 req", {31'h0, perReq}, 0);
    clearLog();
    rdReg(3'd2, 2'd0, rd);
    chk("R1 ctrl", rd, 32'hFFFFFFCC);
    chk("R9 ctrl read no req", reqStarts, 0);
    rdVals[0] = 8'hA5;
    rdReg(3'd1, 2'd0, rd);
    chk("R1 R7 status flag 0", rd, 32'hFFFFFFA4);
    expLog("R7 status op", 0, 7, 8'h00 & perWdata & 8'h00);
  endtask

  task automatic testDataWrite();
    clearLog();
    wr(3'd0, 2'd0, 32'hFF);
    chk("R8 reset value suppressed", reqStarts, 0);
    wr(3'd0, 2'd0, 32'h3C);
    chk("R8 new data one req", reqStarts, 1);
    expLog("R8 data op", 0, 0, 8'h3C);
    wr(3'd0, 2'd0, 32'h3C);
    chk("R8 repeat suppressed", reqStarts, 1);
  endtask

  task automatic testCtrlAndEppWrite();
    logic [31:0] rd;
    clearLog();
    wr(3'd2, 2'd0, 32'h0C);
    chk("R9 equal ctrl suppressed", reqStarts, 0);
    wr(3'd4, 2'd0, 32'h11);
    wr(3'd3, 2'd0, 32'h22);
    chk("R2 gated off no req", reqStarts, 0);
    wr(3'd2, 2'd0, 32'h04);
    chk("R10 single ctrl op", nLog, 1);
    expLog("R10 ctrl full byte", 0, 1, 8'hC4);
    rdReg(3'd2, 2'd0, rd);
    chk("R9 forced bits", rd, 32'hFFFFFFC4);
    clearLog();
    wr(3'd3, 2'd0, 32'h5A);
    expLog("R2 addr write", 0, 3, 8'h5A);
    wr(3'd4, 2'd1, 32'h1234);
    expLog("R4 half lsb", 1, 4, 8'h34);
    expLog("R4 half msb", 2, 4, 8'h12);
    wr(3'd4, 2'd2, 32'hDEADBEEF);
    expLog("R4 word b0", 3, 4, 8'hEF);
    expLog("R4 word b1", 4, 4, 8'hBE);
    expLog("R4 word b2", 5, 4, 8'hAD);
    expLog("R4 word b3", 6, 4, 8'hDE);
    chk("R12 one req per byte", reqStarts, 7);
  endtask

  task automatic testEppRead();
    logic [31:0] rd;
    clearLog();
    rdReg(3'd4, 2'd2, rd);
    chk("R3 gated word ones", rd, 32'hFFFFFFFF);
    rdReg(3'd3, 2'd0, rd);
    chk("R3 gated addr ones", rd, 32'hFFFFFFFF);
    chk("R3 gated no req", reqStarts, 0);
    wr(3'd2, 2'd0, 32'h24);
    chk("R10 two ops", nLog, 2);
    expLog("R10 dir cmd", 0, 2, 8'h01);
    expLog("R10 ctrl dir cleared", 1, 1, 8'hC4);
    clearLog();
    wr(3'd4, 2'd0, 32'h66);
    chk("R2 read pattern blocks write", reqStarts, 0);
    rdVals[0] = 8'h9C;
    rdReg(3'd3, 2'd0, rd);
    chk("R3 addr read", rd, 32'hFFFFFF9C);
    expLog("R3 addr op", 0, 5, logDat[0]);
    clearLog();
    rdVals[0] = 8'h11; rdVals[1] = 8'h22;
    rdReg(3'd4, 2'd1, rd);
    chk("R4 half read", rd, 32'hFFFF2211);
    clearLog();
    rdVals[0] = 8'h01; rdVals[1] = 8'h02; rdVals[2] = 8'h03; rdVals[3] = 8'h04;
    rdReg(3'd4, 2'd3, rd);
    chk("R4 word read", rd, 32'h04030201);
    expLog("R4 data read op", 3, 6, logDat[3]);
  endtask

  task automatic testFailure();
    logic [31:0] rd;
    clearLog();
    errAt = 1;
    rdVals[0] = 8'h11; rdVals[1] = 8'h22; rdVals[2] = 8'h33; rdVals[3] = 8'h44;
    rdReg(3'd4, 2'd2, rd);
    chk("R5 skip after fail lanes", rd, 32'hFFFFFF11);
    chk("R5 skip after fail reqs", reqStarts, 2);
    clearLog();
    rdVals[0] = 8'hF0;
    rdReg(3'd1, 2'd0, rd);
    chk("R5 R7 flag sticky", rd, 32'hFFFFFFF1);
    wr(3'd1, 2'd0, 32'hFE);
    clearLog(); rdVals[0] = 8'hF0;
    rdReg(3'd1, 2'd0, rd);
    chk("R7 bit0 clear keeps flag", rd, 32'hFFFFFFF1);
    wr(3'd1, 2'd0, 32'h01);
    clearLog(); rdVals[0] = 8'hF0;
    rdReg(3'd1, 2'd0, rd);
    chk("R7 flag cleared", rd, 32'hFFFFFFF0);
  endtask

  task automatic testTimeout();
    logic [31:0] rd;
    toLimit = 16'd8;
    clearLog(); ackDelay = 8; rdVals[0] = 8'h5E;
    rdReg(3'd3, 2'd0, rd);
    chk("R6 ack at limit ok", rd, 32'hFFFFFF5E);
    clearLog(); rdVals[0] = 8'h80;
    rdReg(3'd1, 2'd0, rd);
    chk("R6 no flag at limit", rd, 32'hFFFFFF80);
    clearLog(); ackDelay = 9;
    rdReg(3'd3, 2'd0, rd);
    chk("R6 late ack fails", rd, 32'hFFFFFFFF);
    chk("R6 no ack taken", nLog, 0);
    clearLog(); rdVals[0] = 8'h80;
    rdReg(3'd1, 2'd0, rd);
    chk("R5 R6 timeout flag", rd, 32'hFFFFFF81);
    wr(3'd1, 2'd0, 32'h01);
  endtask

  task automatic testTiming();
    logic [31:0] rd; int c; bit w;
    clearLog();
    wr(3'd2, 2'd0, 32'h04);
    expLog("R10 dir back cmd", 0, 2, 8'h00);
    expLog("R10 dir back ctrl", 1, 1, 8'hC4);
    access(1'b0, 3'd2, 2'd0, 32'h0, rd, c, w);
    chk("R11 no-work latency", c, 1);
    chk("R11 no-work no wait", {31'h0, w}, 0);
    clearLog();
    access(1'b1, 3'd0, 2'd0, 32'h55, rd, c, w);
    chk("R11 one-byte latency", c, 2);
    chk("R11 wait seen", {31'h0, w}, 1);
    @(negedge clk);
    chk("R11 done one cycle", {31'h0, hostDone}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataWrite();
    testCtrlAndEppWrite();
    testEppRead();
    testFailure();
    testTimeout();
    testTiming();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule